// File: doc/BRIEF.md
# Read-Response Buffer Map Allocation Engine

The engine keeps the ownership map for sixteen shared read-response buffers. The map sits in two 32-bit registers. One register serves even slots and the other serves odd slots. Each register holds eight 4-bit fields, one per buffer. A field packs an enable flag, a two-bit virtual channel and a one-bit device number. The engine takes one command at a time over a valid/ready handshake. A command can count the fields owned by a slot and channel, count the free fields, take N more fields for an owner, or give N of an owner's fields back. Each command reports a count and a failure flag.

A command picks its register from the slot's low bit. The engine snapshots that register and walks its eight fields one per clock, starting at index 0. When the walk ends, the engine writes the updated register back in the same cycle as the done pulse. A release also yields a 16-bit mask of the global buffer numbers it freed, so downstream drain logic can empty those buffers. Software can overwrite either register and can read both registers at all times.

Top module: `rbm_alloc_engine`

## Requirements
- R1: After reset both map registers read zero, `cmd_ready` is high, and `done` and `free_mask` are low.
- R2: Field i of a register occupies bits [4i+3:4i]. Within a field, bit 3 is enable, bits 2:1 are the channel and bit 0 is the device. A command uses the even register when `cmd_slot[0]`=0 and the odd register otherwise. The owner pattern is {1, chan[1:0], slot[1]}.
- R3: Op 0 (count owned) reports how many fields equal the owner pattern in all four bits, and leaves the map unchanged.
- R4: Op 1 (count free) reports how many fields have enable=0, whatever their other bits hold. It checks only the slot for legality and ignores the channel.
- R5: Op 2 (allocate N) takes free fields lowest index first and writes the full owner pattern into each one. It stops after N fields and reports the number taken.
- R6: If fewer than N free fields exist, the allocation still commits the fields it found, reports their number and raises `done_fail`.
- R7: Op 3 (release N) clears only the enable bit of the lowest-index fields that match the owner, up to N of them. Fewer than N matches is committed and raises `done_fail`.
- R8: With `done`, a release sets `free_mask` bit 2i+p for each field i it cleared in the register of parity p. At all other times `free_mask` is zero.
- R9: A slot above 3, or a channel above 3 for ops 0, 2 and 3, gives `done` with `done_fail`=1 and count 0 one cycle after acceptance. The map is not changed.
- R10: A legal command raises `done` for exactly one cycle, 9 cycles after its acceptance edge. `cmd_ready` stays low while the command runs. The register is written back in the same cycle that `done` goes high.
- R11: `sw_wr` writes `sw_wdata` into the register picked by `sw_sel` (0 even, 1 odd) on the next edge. `cmd_ready` is low while `sw_wr` is high. A software write during a running command is ignored.
- R12: A command never changes the register of the other parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle and able to accept a command |
| cmd_op | input | 2 | 0 count owned, 1 count free, 2 allocate, 3 release |
| cmd_slot | input | 3 | Slot number (0 to 3 legal) |
| cmd_chan | input | 3 | Virtual channel (0 to 3 legal) |
| cmd_num | input | 4 | Requested number for allocate or release |
| sw_wr | input | 1 | Software register write strobe |
| sw_sel | input | 1 | Register chosen for the software write |
| sw_wdata | input | 32 | Software write data |
| map_even | output | 32 | Even-slot map register |
| map_odd | output | 32 | Odd-slot map register |
| done | output | 1 | One-cycle command completion pulse |
| done_count | output | 4 | Result count, valid with done |
| done_fail | output | 1 | Failure or partial fill, valid with done |
| free_mask | output | 16 | Global buffers freed by a release, valid with done |

## Verification
The assertions assume that `cmd_valid` is raised only when the bench has seen `cmd_ready` high. They also assume that `sw_wr` lasts a single cycle and that its data is stable for that cycle. All inputs change on the falling clock edge, so no sampling edge sees a transition. The stimulus presets each register through the software port before it issues a command. It waits for `done` before it issues the next one. The only departures are the deliberate software writes during a running command and while idle, which check that the write is dropped and that `cmd_ready` falls.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    localparam int FIELD_W     = 4;
    localparam int SLOT_W      = 3;
    localparam int CHAN_W      = 3;
    localparam int SLOT_COUNT  = 4;
    localparam int CHAN_COUNT  = 4;
    localparam int DEF_ENTRIES = 8;
    localparam int DEF_NUM_W   = 4;

    typedef enum logic [1:0] {
        OP_COUNT_OWN  = 2'd0,
        OP_COUNT_FREE = 2'd1,
        OP_ALLOC      = 2'd2,
        OP_RELEASE    = 2'd3
    } rbm_op_e;

    typedef struct packed {
        logic       en;
        logic [1:0] vc;
        logic       dev;
    } rbm_field_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } rbm_state_e;

    function automatic rbm_field_t owner_field(input logic [SLOT_W-1:0] slot,
                                               input logic [CHAN_W-1:0] chan);
        rbm_field_t f;
        f.en  = 1'b1;
        f.vc  = chan[1:0];
        f.dev = slot[1];
        return f;
    endfunction

    function automatic logic cmd_legal(input rbm_op_e op,
                                       input logic [SLOT_W-1:0] slot,
                                       input logic [CHAN_W-1:0] chan);
        logic slot_ok;
        logic chan_ok;
        slot_ok = (int'(slot) < SLOT_COUNT);
        chan_ok = (op == OP_COUNT_FREE) || (int'(chan) < CHAN_COUNT);
        return slot_ok && chan_ok;
    endfunction

    function automatic logic op_mutates(input rbm_op_e op);
        return (op == OP_ALLOC) || (op == OP_RELEASE);
    endfunction

endpackage

// File: rtl/rbm_entry_eval.sv
module rbm_entry_eval
    import rbm_pkg::*;
(
    input  rbm_op_e    op,
    input  rbm_field_t cur,
    input  rbm_field_t owner,
    input  logic       want,
    output logic       hit,
    output rbm_field_t nxt
);

    always_comb begin
        nxt = cur;
        hit = 1'b0;
        case (op)
            OP_COUNT_OWN: begin
                hit = (cur == owner);
            end
            OP_COUNT_FREE: begin
                hit = !cur.en;
            end
            OP_ALLOC: begin
                if (!cur.en && want) begin
                    hit = 1'b1;
                    nxt = owner;
                end
            end
            OP_RELEASE: begin
                if ((cur == owner) && want) begin
                    hit    = 1'b1;
                    nxt.en = 1'b0;
                end
            end
            default: begin
                hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rbm_scan_fsm.sv
module rbm_scan_fsm
    import rbm_pkg::*;
#(
    parameter int N_ENTRIES = DEF_ENTRIES,
    parameter int NUM_W     = DEF_NUM_W,
    localparam int REG_W    = N_ENTRIES * FIELD_W,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 start_ok,
    input  rbm_op_e              op_in,
    input  rbm_field_t           owner_in,
    input  logic [NUM_W-1:0]     num_in,
    input  logic [REG_W-1:0]     snap_in,
    output logic                 busy,
    output logic                 commit_en,
    output logic [REG_W-1:0]     commit_data,
    output logic                 done,
    output logic [CNT_W-1:0]     count,
    output logic                 fail,
    output logic [N_ENTRIES-1:0] hit_map
);

    rbm_state_e           state_q;
    logic [IDX_W-1:0]     idx_q;
    rbm_op_e              op_q;
    rbm_field_t           owner_q;
    logic [NUM_W-1:0]     rem_q;
    logic [REG_W-1:0]     work_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [N_ENTRIES-1:0] mask_q;
    logic                 done_q;
    logic                 fail_q;

    rbm_field_t           cur;
    rbm_field_t           nxt;
    logic                 hit;
    logic                 want;
    logic                 take;
    logic                 last;
    logic [NUM_W-1:0]     rem_nxt;
    logic [REG_W-1:0]     work_nxt;

    assign cur      = rbm_field_t'(work_q[FIELD_W-1:0]);
    assign want     = (rem_q != '0);
    assign take     = hit && op_mutates(op_q);
    assign rem_nxt  = rem_q - NUM_W'(take);
    assign work_nxt = {nxt, work_q[REG_W-1:FIELD_W]};
    assign last     = (state_q == ST_SCAN) && (int'(idx_q) == N_ENTRIES - 1);

    rbm_entry_eval u_eval (
        .op    (op_q),
        .cur   (cur),
        .owner (owner_q),
        .want  (want),
        .hit   (hit),
        .nxt   (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            op_q    <= OP_COUNT_OWN;
            owner_q <= '0;
            rem_q   <= '0;
            work_q  <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q  <= '0;
                        mask_q <= '0;
                        if (start_ok) begin
                            state_q <= ST_SCAN;
                            idx_q   <= '0;
                            op_q    <= op_in;
                            owner_q <= owner_in;
                            rem_q   <= num_in;
                            work_q  <= snap_in;
                            fail_q  <= 1'b0;
                        end else begin
                            done_q <= 1'b1;
                            fail_q <= 1'b1;
                        end
                    end
                end
                ST_SCAN: begin
                    work_q <= work_nxt;
                    rem_q  <= rem_nxt;
                    cnt_q  <= cnt_q + CNT_W'(hit);
                    mask_q <= {hit && (op_q == OP_RELEASE), mask_q[N_ENTRIES-1:1]};
                    idx_q  <= idx_q + 1'b1;
                    if (last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        fail_q  <= op_mutates(op_q) && (rem_nxt != '0);
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy        = (state_q == ST_SCAN);
    assign commit_en   = last && op_mutates(op_q);
    assign commit_data = work_nxt;
    assign done        = done_q;
    assign count       = cnt_q;
    assign fail        = fail_q;
    assign hit_map     = mask_q;

endmodule

// File: rtl/rbm_map_regs.sv
module rbm_map_regs #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             sw_wr,
    input  logic             sw_sel,
    input  logic [REG_W-1:0] sw_wdata,
    input  logic             upd_en,
    input  logic             upd_sel,
    input  logic [REG_W-1:0] upd_data,
    output logic [REG_W-1:0] map_even,
    output logic [REG_W-1:0] map_odd
);

    logic [REG_W-1:0] bank_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= '0;
            end else if (upd_en && (upd_sel == 1'(g))) begin
                bank_q[g] <= upd_data;
            end else if (sw_wr && !busy && (sw_sel == 1'(g))) begin
                bank_q[g] <= sw_wdata;
            end
        end
    end

    assign map_even = bank_q[0];
    assign map_odd  = bank_q[1];

endmodule

// File: rtl/rbm_alloc_engine.sv
module rbm_alloc_engine
    import rbm_pkg::*;
#(
    parameter int N_ENTRIES = DEF_ENTRIES,
    parameter int NUM_W     = DEF_NUM_W,
    localparam int REG_W    = N_ENTRIES * FIELD_W,
    localparam int BUF_W    = 2 * N_ENTRIES,
    localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [SLOT_W-1:0] cmd_slot,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic [NUM_W-1:0]  cmd_num,
    input  logic              sw_wr,
    input  logic              sw_sel,
    input  logic [REG_W-1:0]  sw_wdata,
    output logic [REG_W-1:0]  map_even,
    output logic [REG_W-1:0]  map_odd,
    output logic              done,
    output logic [CNT_W-1:0]  done_count,
    output logic              done_fail,
    output logic [BUF_W-1:0]  free_mask
);

    rbm_op_e              op_c;
    logic                 accept;
    logic                 legal;
    logic                 busy;
    logic                 par_q;
    logic [REG_W-1:0]     snap;
    logic                 commit_en;
    logic [REG_W-1:0]     commit_data;
    logic [N_ENTRIES-1:0] hit_map;

    assign op_c      = rbm_op_e'(cmd_op);
    assign legal     = cmd_legal(op_c, cmd_slot, cmd_chan);
    assign cmd_ready = !busy && !sw_wr;
    assign accept    = cmd_valid && cmd_ready;
    assign snap      = cmd_slot[0] ? map_odd : map_even;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= 1'b0;
        end else if (accept) begin
            par_q <= cmd_slot[0];
        end
    end

    rbm_scan_fsm #(
        .N_ENTRIES (N_ENTRIES),
        .NUM_W     (NUM_W)
    ) u_scan (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_ok    (legal),
        .op_in       (op_c),
        .owner_in    (owner_field(cmd_slot, cmd_chan)),
        .num_in      (cmd_num),
        .snap_in     (snap),
        .busy        (busy),
        .commit_en   (commit_en),
        .commit_data (commit_data),
        .done        (done),
        .count       (done_count),
        .fail        (done_fail),
        .hit_map     (hit_map)
    );

    rbm_map_regs #(
        .REG_W (REG_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .sw_wr    (sw_wr),
        .sw_sel   (sw_sel),
        .sw_wdata (sw_wdata),
        .upd_en   (commit_en),
        .upd_sel  (par_q),
        .upd_data (commit_data),
        .map_even (map_even),
        .map_odd  (map_odd)
    );

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_gmask
        assign free_mask[2*i]   = done && !par_q && hit_map[i];
        assign free_mask[2*i+1] = done &&  par_q && hit_map[i];
    end

endmodule

// File: rtl/rbm_alloc_checker.sv
module rbm_alloc_checker #(
    parameter int N_ENTRIES = 8,
    localparam int REG_W    = N_ENTRIES * 4,
    localparam int BUF_W    = 2 * N_ENTRIES,
    localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             sw_wr,
    input logic [REG_W-1:0] map_even,
    input logic [REG_W-1:0] map_odd,
    input logic             done,
    input logic [CNT_W-1:0] done_count,
    input logic [BUF_W-1:0] free_mask
);

    logic [BUF_W-1:0] even_bits;
    always_comb begin
        for (int k = 0; k < BUF_W; k++) begin
            even_bits[k] = (k % 2 == 0);
        end
    end

    // R10: an accepted command leaves the engine busy or finishes at once
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (done || !cmd_ready));

    // R11: the map changes only through a software write or a completion
    p_map_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(sw_wr) && !done) |-> ($stable(map_even) && $stable(map_odd)));

    // R3: no count exceeds the number of fields
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(done_count) <= N_ENTRIES));

    // R8: freed-buffer mask agrees with the reported count
    p_mask_count_r8: assert property (@(posedge clk) disable iff (rst)
        (done && (free_mask != '0)) |-> (int'(done_count) == $countones(free_mask)));

    // R8: one release frees buffers of a single parity only
    p_mask_parity_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (((free_mask & even_bits) == '0) || ((free_mask & ~even_bits) == '0)));

    for (genvar k = 0; k < BUF_W; k++) begin : g_freed
        if (k % 2 == 0) begin : g_even
            // R7: a freed buffer has its enable bit cleared in the map
            p_freed_disabled_r7: assert property (@(posedge clk) disable iff (rst)
                (done && free_mask[k]) |-> !map_even[(k/2)*4+3]);
        end else begin : g_odd
            // R7: a freed buffer has its enable bit cleared in the map
            p_freed_disabled_r7: assert property (@(posedge clk) disable iff (rst)
                (done && free_mask[k]) |-> !map_odd[(k/2)*4+3]);
        end
    end

endmodule

bind rbm_alloc_engine rbm_alloc_checker #(
    .N_ENTRIES (N_ENTRIES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .sw_wr      (sw_wr),
    .map_even   (map_even),
    .map_odd    (map_odd),
    .done       (done),
    .done_count (done_count),
    .free_mask  (free_mask)
);

// File: tb/test_rbm_alloc_engine.sv
`timescale 1ns/1ps
module test_rbm_alloc_engine;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_slot;
    logic [2:0]  cmd_chan;
    logic [3:0]  cmd_num;
    logic        sw_wr;
    logic        sw_sel;
    logic [31:0] sw_wdata;
    logic [31:0] map_even;
    logic [31:0] map_odd;
    logic        done;
    logic [3:0]  done_count;
    logic        done_fail;
    logic [15:0] free_mask;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(HALF) clk = ~clk;

    rbm_alloc_engine i_rbm_alloc_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_chan(cmd_chan), .cmd_num(cmd_num),
        .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .map_even(map_even), .map_odd(map_odd), .done(done),
        .done_count(done_count), .done_fail(done_fail), .free_mask(free_mask)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  slot;
        logic [2:0]  chan;
        logic [3:0]  num;
        logic [31:0] preset;
        logic [31:0] other;
        logic [3:0]  cnt;
        logic        fail;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 3'd0, 4'd0, 32'h0009_8088, 32'h1234_5678, 4'd3, 1'b0},
        '{2'd1, 3'd1, 3'd0, 4'd0, 32'hF7F0_8A7C, 32'hAAAA_AAAA, 4'd3, 1'b0},
        '{2'd2, 3'd2, 3'd1, 4'd2, 32'h8888_8808, 32'h0000_0000, 4'd1, 1'b1},
        '{2'd2, 3'd3, 3'd3, 4'd3, 32'h0707_8888, 32'h5555_5555, 4'd3, 1'b0},
        '{2'd3, 3'd1, 3'd2, 4'd2, 32'hC0CC_4C8C, 32'hCCCC_CCCC, 4'd2, 1'b0},
        '{2'd3, 3'd0, 3'd0, 4'd5, 32'h0000_0818, 32'h8888_8888, 4'd2, 1'b1},
        '{2'd2, 3'd0, 3'd0, 4'd0, 32'h0000_0000, 32'h0000_0000, 4'd0, 1'b0},
        '{2'd1, 3'd2, 3'd7, 4'd0, 32'h0000_0000, 32'hFFFF_FFFF, 4'd8, 1'b0},
        '{2'd2, 3'd4, 3'd0, 4'd1, 32'h0000_0000, 32'h0000_0000, 4'd0, 1'b1},
        '{2'd3, 3'd1, 3'd4, 4'd1, 32'h0000_000C, 32'h0000_0000, 4'd0, 1'b1},
        '{2'd0, 3'd3, 3'd2, 4'd0, 32'hDDD5_D5DD, 32'h0000_0000, 4'd6, 1'b0},
        '{2'd2, 3'd1, 3'd0, 4'd8, 32'h0700_0000, 32'h0000_0000, 4'd8, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_legal(input logic [1:0] op, input logic [2:0] slot, input logic [2:0] chan);
        return (slot < 3'd4) && ((op == 2'd1) || (chan < 3'd4));
    endfunction

    function automatic string op_tag(input logic [1:0] op, input bit legal, input bit pfail);
        if (!legal)       return "R9";
        if (op == 2'd0)   return "R3";
        if (op == 2'd1)   return "R4";
        if (op == 2'd2)   return pfail ? "R6" : "R5";
        return "R7";
    endfunction

    task automatic model(input logic [1:0] op, input logic [2:0] slot, input logic [2:0] chan,
                         input logic [3:0] num, input logic [31:0] cur,
                         output logic [31:0] nmap, output logic [15:0] nmask);
        logic [3:0] own;
        int left;
        nmap  = cur;
        nmask = '0;
        if (is_legal(op, slot, chan)) begin
            own  = {1'b1, chan[1:0], slot[1]};
            left = int'(num);
            for (int i = 0; i < 8; i++) begin
                if (op == 2'd2 && !cur[4*i+3] && left > 0) begin
                    nmap[4*i +: 4] = own;
                    left--;
                end else if (op == 2'd3 && cur[4*i +: 4] == own && left > 0) begin
                    nmap[4*i+3] = 1'b0;
                    nmask[2*i + int'(slot[0])] = 1'b1;
                    left--;
                end
            end
        end
    endtask

    task automatic sw_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        sw_wr    = 1'b1;
        sw_sel   = sel;
        sw_wdata = data;
        @(negedge clk);
        sw_wr    = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] slot, input logic [2:0] chan,
                         input logic [3:0] num, output int lat, output bit ready_mid);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_slot  = slot;
        cmd_chan  = chan;
        cmd_num   = num;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat       = 1;
        ready_mid = cmd_ready;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] emap;
        logic [15:0] emask;
        logic [31:0] selmap;
        logic [31:0] othmap;
        int lat;
        bit rmid;
        bit legal;

        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_slot = '0; cmd_chan = '0; cmd_num = '0;
        sw_wr = 1'b0; sw_sel = 1'b0; sw_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(map_even == 32'h0 && map_odd == 32'h0, "R1", map_even | map_odd, 32'h0);
        chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'h1);
        chk(done == 1'b0 && free_mask == '0, "R1", {done, 15'h0, free_mask}, 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            string tag;
            t = VEC[v];
            legal = is_legal(t.op, t.slot, t.chan);
            tag = op_tag(t.op, legal, t.fail);
            sw_write(t.slot[0], t.preset);
            sw_write(~t.slot[0], t.other);
            model(t.op, t.slot, t.chan, t.num, t.preset, emap, emask);
            issue(t.op, t.slot, t.chan, t.num, lat, rmid);
            chk(done == 1'b1, tag, 32'(done), 32'h1);
            chk(done_count == t.cnt, tag, 32'(done_count), 32'(t.cnt));
            chk(done_fail == t.fail, tag, 32'(done_fail), 32'(t.fail));
            selmap = t.slot[0] ? map_odd : map_even;
            othmap = t.slot[0] ? map_even : map_odd;
            // R2: field layout and parity select seen in the written register
            chk(selmap == emap, (t.op >= 2'd2 && legal) ? "R2" : tag, selmap, emap);
            chk(othmap == t.other, "R12", othmap, t.other);
            chk(free_mask == emask, "R8", 32'(free_mask), 32'(emask));
            chk(lat == (legal ? 9 : 1), legal ? "R10" : "R9", 32'(lat), legal ? 32'd9 : 32'd1);
            if (legal) chk(rmid == 1'b0, "R10", 32'(rmid), 32'h0);
            @(negedge clk);
            chk(done == 1'b0 && free_mask == '0, "R10", {done, 15'h0, free_mask}, 32'h0);
        end

        // R11: cmd_ready low during a software write while idle
        @(negedge clk);
        sw_wr = 1'b1; sw_sel = 1'b1; sw_wdata = 32'h0000_0123;
        #1;
        chk(cmd_ready == 1'b0, "R11", 32'(cmd_ready), 32'h0);
        @(negedge clk);
        sw_wr = 1'b0;
        chk(map_odd == 32'h0000_0123, "R11", map_odd, 32'h0000_0123);

        // R11: software write ignored while a command runs
        sw_write(1'b0, 32'h0000_0000);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_slot = 3'd0; cmd_chan = 3'd0; cmd_num = 4'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R10", 32'(cmd_ready), 32'h0);
        sw_wr = 1'b1; sw_sel = 1'b0; sw_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        sw_wr = 1'b0;
        chk(map_even == 32'h0, "R11", map_even, 32'h0);
        lat = 2;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 9, "R10", 32'(lat), 32'd9);
        chk(map_even == 32'h0000_0088, "R11", map_even, 32'h0000_0088);
        chk(done_count == 4'd2 && done_fail == 1'b0, "R5", {done_fail, done_count}, 32'h2);

        // R7: release leaves channel and device bits, frees buffers 0 and 2
        @(negedge clk);
        issue(2'd3, 3'd0, 3'd0, 4'd2, lat, rmid);
        chk(map_even == 32'h0000_0000, "R7", map_even, 32'h0);
        chk(free_mask == 16'h0005, "R8", 32'(free_mask), 32'h5);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule